// File: doc/BRIEF.md
# Three-Level Leg Sequential Shutdown Controller

This block sits between the modulator and the gate drive of one phase leg of an active neutral-point clamped three-level converter. Four PWM commands enter, one per switch: outer-upper, inner-upper, inner-lower and outer-lower. Four gate commands leave the block. While all is healthy, the gate commands follow the PWM commands one clock later. Any ordering of switches during a normal start or stop is left to the system controller.

The block watches three fault sources on every clock:
- per-switch desaturation flags,
- a supply undervoltage flag,
- the PWM pattern itself.

When any source becomes active, the block takes the leg away from the controller and runs its own shutdown. The outer switches open at once. The inner switches hold their state for a fixed number of clock cycles and then open. The block then stays latched with all gates off and reports the first cause. It leaves this state only when a clear pulse arrives while every fault source is quiet.

Top module: `tl_leg_shutdown`

## Requirements
- R1: While reset is asserted and on leaving reset, all four gate outputs are 0, `fault_o` is 0 and `cause_o` is 0.
- R2: With no fault latched and no fault source active, `gate_o` equals the `pwm_i` value sampled at the previous rising clock edge. Bit order in both vectors: bit 0 outer-upper, bit 1 inner-upper, bit 2 inner-lower, bit 3 outer-lower.
- R3: When any `desat_i` bit is 1 in the run state, `fault_o` is 1 after the next clock edge and `cause_o` reads 1 (device fault).
- R4: An abnormal control pattern is one of two cases. The first is an outer switch commanded on while the inner switch on the same side is commanded off (bit 0 without bit 1, or bit 3 without bit 2). The second is both outer switches commanded on together. Such a pattern latches a fault with `cause_o` = 2.
- R5: When `uv_i` is 1 in the run state, a fault latches with `cause_o` = 3.
- R6: At the clock edge that latches a fault, both outer gate outputs go to 0 and both inner gate outputs keep their previous values. Exactly `GAP_CYC` clock edges later, both inner outputs go to 0. No inner output turns off during a fault while an outer output is still on.
- R7: From the fault-latching edge onward, `pwm_i` has no effect on `gate_o` until the fault is cleared.
- R8: `cause_o` keeps the first detected cause until the fault is cleared. If several sources rise in the same cycle, the lowest code wins (1 before 2 before 3).
- R9: The fault leaves the latched state only when `clr_i` is 1 on a clock edge after the inner switches are off and no fault source is active at that edge. A clear given during the timed shutdown, or while a source is active, is ignored.
- R10: At the clearing edge, `fault_o` and `cause_o` return to 0 and all gate outputs stay 0. From the next edge on, the gate outputs again follow `pwm_i` as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwm_i | input | 4 | PWM commands from the controller (bit 0 OU, 1 IU, 2 IL, 3 OL) |
| desat_i | input | 4 | Per-switch desaturation fault flags, same bit order |
| uv_i | input | 1 | Supply undervoltage flag |
| clr_i | input | 1 | Fault clear request |
| gate_o | output | 4 | Gate commands, same bit order |
| fault_o | output | 1 | Fault latched / shutdown active |
| cause_o | output | 2 | First fault cause: 0 none, 1 device, 2 control pattern, 3 supply |

## Verification
The bench builds the block with `GAP_CYC` = 6 instead of the default of 250, which is 2 µs at 125 MHz. With the short gap, the bench can walk every cycle of the outer-to-inner window and confirm that the inner gates fall on exactly the sixth edge. It can also try a clear pulse and hostile PWM patterns in the middle of that window. The bound checker counts the same window from its own counter, so the timing is checked for any gap value.

// File: rtl/tl_shut_pkg.sv
package tl_shut_pkg;

    localparam int NSW   = 4;
    localparam int SW_OU = 0;
    localparam int SW_IU = 1;
    localparam int SW_IL = 2;
    localparam int SW_OL = 3;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_WAIT  = 2'd1,
        ST_LATCH = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        GM_PASS      = 2'd0,
        GM_OUTER_OFF = 2'd1,
        GM_ALL_OFF   = 2'd2
    } gate_mode_e;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_DEVICE = 2'd1,
        CAUSE_CTRL   = 2'd2,
        CAUSE_SUPPLY = 2'd3
    } cause_e;

    function automatic logic is_outer(input int idx);
        return (idx == SW_OU) || (idx == SW_OL);
    endfunction

endpackage

// File: rtl/tl_fault_detect.sv
module tl_fault_detect
    import tl_shut_pkg::*;
(
    input  logic [NSW-1:0] pwm_i,
    input  logic [NSW-1:0] desat_i,
    input  logic           uv_i,
    output logic           src_act_o,
    output cause_e         src_code_o
);
    localparam int NSIDE = 2;

    // per side: outer index, inner index
    logic [NSIDE-1:0] side_bad;

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        localparam int OUT_IX = (s == 0) ? SW_OU : SW_OL;
        localparam int IN_IX  = (s == 0) ? SW_IU : SW_IL;
        assign side_bad[s] = pwm_i[OUT_IX] & ~pwm_i[IN_IX];
    end

    logic dev_flt;
    logic ctl_flt;

    always_comb begin
        dev_flt = |desat_i;
        ctl_flt = (|side_bad) | (pwm_i[SW_OU] & pwm_i[SW_OL]);
        src_act_o = dev_flt | ctl_flt | uv_i;
        if (dev_flt) begin
            src_code_o = CAUSE_DEVICE;
        end else if (ctl_flt) begin
            src_code_o = CAUSE_CTRL;
        end else if (uv_i) begin
            src_code_o = CAUSE_SUPPLY;
        end else begin
            src_code_o = CAUSE_NONE;
        end
    end

endmodule

// File: rtl/tl_shut_seq.sv
module tl_shut_seq
    import tl_shut_pkg::*;
#(
    parameter int GAP_CYC = 250
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       src_act_i,
    input  cause_e     src_code_i,
    input  logic       clr_i,
    output gate_mode_e mode_o,
    output logic       fault_o,
    output logic [1:0] cause_o
);
    localparam int CW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(GAP_CYC - 1);

    typedef struct packed {
        seq_state_e    state;
        logic [CW-1:0] cnt;
        logic          fault;
        cause_e        cause;
    } seq_reg_t;

    seq_reg_t seq_d, seq_q;
    gate_mode_e mode_d;

    always_comb begin
        seq_d  = seq_q;
        mode_d = GM_PASS;
        case (seq_q.state)
            ST_RUN: begin
                if (src_act_i) begin
                    seq_d.state = ST_WAIT;
                    seq_d.cnt   = '0;
                    seq_d.fault = 1'b1;
                    seq_d.cause = src_code_i;
                    mode_d      = GM_OUTER_OFF;
                end
            end
            ST_WAIT: begin
                mode_d = GM_OUTER_OFF;
                if (seq_q.cnt == CNT_LAST) begin
                    mode_d      = GM_ALL_OFF;
                    seq_d.state = ST_LATCH;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            ST_LATCH: begin
                mode_d = GM_ALL_OFF;
                if (clr_i && !src_act_i) begin
                    seq_d.state = ST_RUN;
                    seq_d.fault = 1'b0;
                    seq_d.cause = CAUSE_NONE;
                end
            end
            default: begin
                mode_d      = GM_ALL_OFF;
                seq_d.state = ST_LATCH;
                seq_d.fault = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '{state: ST_RUN, cnt: '0, fault: 1'b0, cause: CAUSE_NONE};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign mode_o  = mode_d;
    assign fault_o = seq_q.fault;
    assign cause_o = seq_q.cause;

endmodule

// File: rtl/tl_gate_stage.sv
module tl_gate_stage
    import tl_shut_pkg::*;
(
    input  logic           clk_i,
    input  logic           rst_ni,
    input  gate_mode_e     mode_i,
    input  logic [NSW-1:0] pwm_i,
    output logic [NSW-1:0] gate_o
);
    typedef struct packed {
        logic [NSW-1:0] gate;
    } gate_reg_t;

    gate_reg_t gate_d, gate_q;
    logic [NSW-1:0] nxt;

    for (genvar i = 0; i < NSW; i++) begin : g_sw
        localparam logic OUTER = is_outer(i);
        always_comb begin
            case (mode_i)
                GM_PASS:      nxt[i] = pwm_i[i];
                GM_OUTER_OFF: nxt[i] = OUTER ? 1'b0 : gate_q.gate[i];
                default:      nxt[i] = 1'b0;
            endcase
        end
    end

    always_comb begin
        gate_d      = gate_q;
        gate_d.gate = nxt;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            gate_q <= '{gate: '0};
        end else begin
            gate_q <= gate_d;
        end
    end

    assign gate_o = gate_q.gate;

endmodule

// File: rtl/tl_leg_shutdown.sv
module tl_leg_shutdown
    import tl_shut_pkg::*;
#(
    parameter int GAP_CYC = 250
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [3:0] pwm_i,
    input  logic [3:0] desat_i,
    input  logic       uv_i,
    input  logic       clr_i,
    output logic [3:0] gate_o,
    output logic       fault_o,
    output logic [1:0] cause_o
);
    logic       src_act;
    cause_e     src_code;
    gate_mode_e mode;

    tl_fault_detect u_det (
        .pwm_i      (pwm_i),
        .desat_i    (desat_i),
        .uv_i       (uv_i),
        .src_act_o  (src_act),
        .src_code_o (src_code)
    );

    tl_shut_seq #(.GAP_CYC(GAP_CYC)) u_seq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .src_act_i  (src_act),
        .src_code_i (src_code),
        .clr_i      (clr_i),
        .mode_o     (mode),
        .fault_o    (fault_o),
        .cause_o    (cause_o)
    );

    tl_gate_stage u_gate (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .mode_i (mode),
        .pwm_i  (pwm_i),
        .gate_o (gate_o)
    );

endmodule

// File: rtl/tl_leg_shutdown_chk.sv
module tl_leg_shutdown_chk #(
    parameter int GAP_CYC = 250
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [3:0] pwm_i,
    input logic [3:0] desat_i,
    input logic       uv_i,
    input logic       clr_i,
    input logic [3:0] gate_o,
    input logic       fault_o,
    input logic [1:0] cause_o
);
    localparam int KW = $clog2(GAP_CYC + 2);

    logic          armed_q;
    logic [KW-1:0] win_q;
    logic          bad_pat;
    logic          inner_on;

    assign bad_pat  = (pwm_i[0] & ~pwm_i[1]) | (pwm_i[3] & ~pwm_i[2]) | (pwm_i[0] & pwm_i[3]);
    assign inner_on = gate_o[1] | gate_o[2];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            armed_q <= 1'b0;
            win_q   <= '0;
        end else begin
            armed_q <= 1'b1;
            if (!fault_o) begin
                win_q <= '0;
            end else if (win_q <= KW'(GAP_CYC)) begin
                win_q <= win_q + 1'b1;
            end
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk_i)
        !rst_ni |-> (gate_o == 4'b0000 && !fault_o && cause_o == 2'd0));

    // R2
    pass_through_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed_q && !fault_o && !$past(fault_o) |-> gate_o == $past(pwm_i));

    // R3
    device_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fault_o && (|desat_i) |=> fault_o && cause_o == 2'd1);

    // R4
    ctrl_detect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fault_o && bad_pat |=> fault_o);

    // R5
    supply_detect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fault_o && uv_i |=> fault_o);

    // R6
    outer_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed_q && fault_o && $past(fault_o) && ($fell(gate_o[1]) || $fell(gate_o[2]))
        |-> $past(gate_o[0] == 1'b0 && gate_o[3] == 1'b0));

    // R6
    gap_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed_q && fault_o && !inner_on && $past(inner_on) && $past(fault_o)
        |-> win_q == KW'(GAP_CYC));

    // R7
    all_off_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o && gate_o == 4'b0000 |=> gate_o == 4'b0000);

    // R8
    cause_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o && !clr_i |=> fault_o && $stable(cause_o));

    // R8
    cause_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |-> cause_o != 2'd0);

    // R9
    clear_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o && ((|desat_i) || uv_i || bad_pat || inner_on) |=> fault_o);

endmodule

bind tl_leg_shutdown tl_leg_shutdown_chk #(.GAP_CYC(GAP_CYC)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pwm_i   (pwm_i),
    .desat_i (desat_i),
    .uv_i    (uv_i),
    .clr_i   (clr_i),
    .gate_o  (gate_o),
    .fault_o (fault_o),
    .cause_o (cause_o)
);

// File: tb/tl_leg_shutdown_tb.sv
module tl_leg_shutdown_tb;

    localparam int GAP = 6;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic [3:0] pwm_i = '0;
    logic [3:0] desat_i = '0;
    logic       uv_i = 1'b0;
    logic       clr_i = 1'b0;
    logic [3:0] gate_o;
    logic       fault_o;
    logic [1:0] cause_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk_i = ~clk_i;

    tl_leg_shutdown #(.GAP_CYC(GAP)) u_dut (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pwm_i   (pwm_i),
        .desat_i (desat_i),
        .uv_i    (uv_i),
        .clr_i   (clr_i),
        .gate_o  (gate_o),
        .fault_o (fault_o),
        .cause_o (cause_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_out(input string req, input logic [3:0] g, input logic f, input logic [1:0] c);
        chk(gate_o === g, {req, " gate"}, gate_o, g);
        chk(fault_o === f, {req, " fault"}, fault_o, f);
        chk(cause_o === c, {req, " cause"}, cause_o, c);
    endtask

    task automatic step();
        @(posedge clk_i);
        @(negedge clk_i);
    endtask

    // clear a latched fault with all sources quiet; R10 gates stay off at the clear edge
    task automatic do_clear(input logic [3:0] pwm_next);
        desat_i = '0;
        uv_i    = 1'b0;
        pwm_i   = pwm_next;
        clr_i   = 1'b1;
        step();
        clr_i = 1'b0;
        chk_out("R10 clear edge", 4'b0000, 1'b0, 2'd0);
        step();
        chk(gate_o === pwm_next, "R10 follow after clear", gate_o, pwm_next);
    endtask

    // walk the timed window; inner outputs held until edge GAP
    task automatic walk_gap(input string req, input logic [3:0] held, input logic [1:0] c);
        for (int j = 1; j < GAP; j++) begin
            pwm_i = (j % 2) ? 4'b1111 : 4'b1001; // R7 hostile patterns
            step();
            chk_out({req, " R6 hold"}, held, 1'b1, c);
        end
        step();
        chk_out({req, " R6 inner off"}, 4'b0000, 1'b1, c);
    endtask

    task automatic t_reset();
        rst_ni = 1'b0;
        pwm_i  = 4'b0110;
        repeat (3) @(negedge clk_i);
        chk_out("R1 in reset", 4'b0000, 1'b0, 2'd0);
        pwm_i  = '0;
        rst_ni = 1'b1;
        step();
        chk_out("R1 after reset", 4'b0000, 1'b0, 2'd0);
    endtask

    task automatic t_pass();
        logic [3:0] pats [5] = '{4'b0110, 4'b0011, 4'b1100, 4'b0010, 4'b0000};
        foreach (pats[k]) begin
            pwm_i = pats[k];
            step();
            chk_out("R2 pass", pats[k], 1'b0, 2'd0);
        end
    endtask

    task automatic t_device();
        pwm_i = 4'b0011;
        step();
        desat_i = 4'b0100;
        step();
        chk_out("R3 device", 4'b0010, 1'b1, 2'd1);
        walk_gap("R3", 4'b0010, 2'd1);
        pwm_i = 4'b0110;
        repeat (3) step();
        chk_out("R7 latched ignores pwm", 4'b0000, 1'b1, 2'd1);
        clr_i = 1'b1; // desat still active
        step();
        clr_i = 1'b0;
        chk_out("R9 clear with source", 4'b0000, 1'b1, 2'd1);
        do_clear(4'b0110);
    endtask

    task automatic t_ctrl_side();
        pwm_i = 4'b0011;
        step();
        pwm_i = 4'b0001; // outer-upper without inner-upper
        step();
        chk_out("R4 side pattern", 4'b0010, 1'b1, 2'd2);
        walk_gap("R4", 4'b0010, 2'd2);
        uv_i = 1'b1;
        step();
        chk_out("R8 later source", 4'b0000, 1'b1, 2'd2);
        uv_i = 1'b0;
        do_clear(4'b0000);
    endtask

    task automatic t_ctrl_outer();
        pwm_i = 4'b0110;
        step();
        pwm_i = 4'b1111; // both outer on
        step();
        chk_out("R4 both outer", 4'b0110, 1'b1, 2'd2);
        walk_gap("R4b", 4'b0110, 2'd2);
        do_clear(4'b1100);
    endtask

    task automatic t_supply_midclear();
        pwm_i = 4'b1100;
        step();
        uv_i = 1'b1;
        step();
        chk_out("R5 supply", 4'b0100, 1'b1, 2'd3);
        for (int j = 1; j < GAP; j++) begin
            if (j == 2) begin
                uv_i  = 1'b0;
                pwm_i = 4'b0000;
                clr_i = 1'b1; // R9 clear during window ignored
            end else begin
                clr_i = 1'b0;
            end
            step();
            chk_out("R9 window clear ignored", 4'b0100, 1'b1, 2'd3);
        end
        clr_i = 1'b0;
        step();
        chk_out("R6 supply inner off", 4'b0000, 1'b1, 2'd3);
        do_clear(4'b0011);
    endtask

    task automatic t_priority();
        pwm_i = 4'b0110;
        step();
        desat_i = 4'b1000;
        uv_i    = 1'b1;
        pwm_i   = 4'b1001;
        step();
        chk_out("R8 priority", 4'b0110, 1'b1, 2'd1);
        walk_gap("R8", 4'b0110, 2'd1);
        do_clear(4'b0000);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk_i);
        t_reset();
        t_pass();
        t_device();
        t_ctrl_side();
        t_ctrl_outer();
        t_supply_midclear();
        t_priority();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule